// File: doc/BRIEF.md
# Priority Throttle Setting Arbiter

This block picks one throttle setting out of several throttle event sources, such as a light thermal alarm, a heavy thermal alarm and an overcurrent alarm. Each source supplies four things: an active flag, a priority value, a CPU clock skip depth in percent and a GPU skip level code. Among the sources that are active, the one with the largest priority wins. Its CPU depth and GPU level become the final throttle setting, and the block also reports the index of the winning source.

Priority values are limited to the range 1 to 100 before they are compared. When two priorities are equal, the lower source index wins, so the result is always the same for the same inputs. When no source is active, the block outputs a neutral setting with the valid flag low. All outputs are registered. The stage that applies the setting to the clock skippers is not part of this block.

Top module: `throttle_arbiter`

## Requirements
- R1: While reset is asserted, and right after it is released, valid_o is 0, win_idx_o is 0, cpu_pct_o is 0 and gpu_lvl_o is 0 (NONE).
- R2: When exactly one source is active, that source's CPU depth, GPU level and index appear on the outputs and valid_o is 1. GPU level codes are: 0 = NONE (0 %), 1 = LOW (50 %), 2 = MED (75 %), 3 = HIGH (85 %). Source i uses bit i of act_i and slice i of each flat input vector.
- R3: When several sources are active, the active source with the numerically largest priority supplies the outputs.
- R4: When active sources share the largest priority, the one with the lowest index wins.
- R5: When no source is active, valid_o is 0, win_idx_o is 0, cpu_pct_o is 0 and gpu_lvl_o is 0, whatever the other inputs hold.
- R6: Before comparison, a priority below 1 is treated as 1 and a priority above 100 is treated as 100.
- R7: The outputs show the inputs sampled at the previous rising clock edge. They do not change between edges.
- R8: The priority and payload of an inactive source have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | N_SRC | Per-source active flags |
| prio_i | input | N_SRC*PRIO_W | Per-source priority values, packed flat |
| cpu_pct_i | input | N_SRC*PCT_W | Per-source CPU skip depth in percent, packed flat |
| gpu_lvl_i | input | N_SRC*LVL_W | Per-source GPU level code, packed flat |
| valid_o | output | 1 | At least one source was active at the last edge |
| win_idx_o | output | IDX_W | Index of the winning source |
| cpu_pct_o | output | PCT_W | Selected CPU skip depth |
| gpu_lvl_o | output | LVL_W | Selected GPU level code |

## Verification
Every result (valid, index, depth and level) is due exactly one rising edge after the inputs that produce it. The bench changes inputs on the falling edge and compares the outputs on the next falling edge, which is one full register stage later. For the latency requirement, the bench also samples just after it changes the inputs, before the rising edge, to confirm the old setting is still held. The reset check is taken while reset is held and again after an asynchronous reset in the middle of a run.

// File: rtl/thr_arb_pkg.sv
package thr_arb_pkg;
  typedef enum logic [1:0] {
    GPU_NONE = 2'd0,
    GPU_LOW  = 2'd1,
    GPU_MED  = 2'd2,
    GPU_HIGH = 2'd3
  } gpu_lvl_e;

  localparam int unsigned PRIO_LO = 1;
  localparam int unsigned PRIO_HI = 100;
endpackage

// File: rtl/thr_prio_clamp.sv
module thr_prio_clamp
  import thr_arb_pkg::*;
#(
  parameter int unsigned PRIO_W = 7
) (
  input  logic [PRIO_W-1:0] raw_i,
  output logic [PRIO_W-1:0] clamped_o
);
  localparam logic [PRIO_W-1:0] LO = PRIO_W'(PRIO_LO);
  localparam logic [PRIO_W-1:0] HI = PRIO_W'(PRIO_HI);

  always_comb begin
    if (raw_i < LO)      clamped_o = LO;
    else if (raw_i > HI) clamped_o = HI;
    else                 clamped_o = raw_i;
  end
endmodule

// File: rtl/thr_select.sv
module thr_select #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned PRIO_W = 7,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [N_SRC-1:0]        act_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [PRIO_W-1:0] best;

  // ascending scan, strict greater: lowest index keeps a tie
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (act_i[i] && (!hit_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/thr_out_reg.sv
module thr_out_reg #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned PCT_W = 7,
  parameter int unsigned LVL_W = 2,
  parameter int unsigned IDX_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hit_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [N_SRC*PCT_W-1:0] cpu_pct_i,
  input  logic [N_SRC*LVL_W-1:0] gpu_lvl_i,
  output logic                   valid_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [PCT_W-1:0]       cpu_pct_o,
  output logic [LVL_W-1:0]       gpu_lvl_o
);
  logic [PCT_W-1:0] pct_sel;
  logic [LVL_W-1:0] lvl_sel;

  always_comb begin
    pct_sel = '0;
    lvl_sel = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (hit_i && idx_i == IDX_W'(i)) begin
        pct_sel = cpu_pct_i[i*PCT_W +: PCT_W];
        lvl_sel = gpu_lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      win_idx_o <= '0;
      cpu_pct_o <= '0;
      gpu_lvl_o <= '0;
    end else begin
      valid_o   <= hit_i;
      win_idx_o <= hit_i ? idx_i : '0;
      cpu_pct_o <= pct_sel;
      gpu_lvl_o <= lvl_sel;
    end
  end
endmodule

// File: rtl/throttle_arbiter.sv
module throttle_arbiter #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned PRIO_W = 7,
  parameter int unsigned PCT_W  = 7,
  parameter int unsigned LVL_W  = 2,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        act_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [N_SRC*PCT_W-1:0]  cpu_pct_i,
  input  logic [N_SRC*LVL_W-1:0]  gpu_lvl_i,
  output logic                    valid_o,
  output logic [IDX_W-1:0]        win_idx_o,
  output logic [PCT_W-1:0]        cpu_pct_o,
  output logic [LVL_W-1:0]        gpu_lvl_o
);
  logic [N_SRC*PRIO_W-1:0] prio_c;
  logic                    hit;
  logic [IDX_W-1:0]        idx;

  for (genvar g = 0; g < N_SRC; g++) begin : g_clamp
    thr_prio_clamp #(.PRIO_W(PRIO_W)) u_clamp (
      .raw_i     (prio_i[g*PRIO_W +: PRIO_W]),
      .clamped_o (prio_c[g*PRIO_W +: PRIO_W])
    );
  end

  thr_select #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .act_i  (act_i),
    .prio_i (prio_c),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  thr_out_reg #(.N_SRC(N_SRC), .PCT_W(PCT_W), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .idx_i     (idx),
    .cpu_pct_i (cpu_pct_i),
    .gpu_lvl_i (gpu_lvl_i),
    .valid_o   (valid_o),
    .win_idx_o (win_idx_o),
    .cpu_pct_o (cpu_pct_o),
    .gpu_lvl_o (gpu_lvl_o)
  );
endmodule

// File: rtl/thr_arb_chk.sv
module thr_arb_chk #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned PRIO_W = 7,
  parameter int unsigned PCT_W  = 7,
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned IDX_W  = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC-1:0]        act_i,
  input logic [N_SRC*PRIO_W-1:0] prio_i,
  input logic [N_SRC*PCT_W-1:0]  cpu_pct_i,
  input logic [N_SRC*LVL_W-1:0]  gpu_lvl_i,
  input logic                    valid_o,
  input logic [IDX_W-1:0]        win_idx_o,
  input logic [PCT_W-1:0]        cpu_pct_o,
  input logic [LVL_W-1:0]        gpu_lvl_o
);
  function automatic int unsigned lim(input logic [PRIO_W-1:0] p);
    if (int'(p) < 1)   return 1;
    if (int'(p) > 100) return 100;
    return int'(p);
  endfunction

  logic [N_SRC-1:0]  act_q;
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [PCT_W-1:0]  pct_q  [N_SRC];
  logic [LVL_W-1:0]  lvl_q  [N_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      for (int i = 0; i < N_SRC; i++) begin
        prio_q[i] <= '0;
        pct_q[i]  <= '0;
        lvl_q[i]  <= '0;
      end
    end else begin
      act_q <= act_i;
      for (int i = 0; i < N_SRC; i++) begin
        prio_q[i] <= prio_i[i*PRIO_W +: PRIO_W];
        pct_q[i]  <= cpu_pct_i[i*PCT_W +: PCT_W];
        lvl_q[i]  <= gpu_lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|act_i) |=> (!valid_o && win_idx_o == '0 && cpu_pct_o == '0 && gpu_lvl_o == '0)); // R5
  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act_i) |=> valid_o); // R7
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'(win_idx_o) < N_SRC)); // R2
  AST_WIN_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> act_q[win_idx_o]); // R8
  AST_PAYLOAD_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cpu_pct_o == pct_q[win_idx_o] && gpu_lvl_o == lvl_q[win_idx_o])); // R2

  for (genvar j = 0; j < N_SRC; j++) begin : g_rank
    AST_MAX_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && act_q[j]) |-> lim(prio_q[j]) <= lim(prio_q[win_idx_o])); // R3 R6
    AST_TIE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && act_q[j] && j < int'(win_idx_o)) |-> lim(prio_q[j]) < lim(prio_q[win_idx_o])); // R4
  end
endmodule

bind throttle_arbiter thr_arb_chk #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .PCT_W(PCT_W), .LVL_W(LVL_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act_i), .prio_i(prio_i),
  .cpu_pct_i(cpu_pct_i), .gpu_lvl_i(gpu_lvl_i), .valid_o(valid_o),
  .win_idx_o(win_idx_o), .cpu_pct_o(cpu_pct_o), .gpu_lvl_o(gpu_lvl_o)
);

// File: tb/tb_throttle_arbiter.sv
module tb_throttle_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [2:0] act;
    logic [6:0] p0, p1, p2;
    logic [3:0] req;
    logic       ev;
    logic [1:0] eidx;
    logic [6:0] epct;
    logic [1:0] elvl;
  } vec_t;

  // src0: 85%/HIGH(3), src1: 50%/LOW(1), src2: 75%/MED(2)
  localparam vec_t VEC [NV] = '{
    '{3'b000, 7'd100, 7'd80,  7'd50, 4'd5, 1'b0, 2'd0, 7'd0,  2'd0}, // R5
    '{3'b001, 7'd100, 7'd80,  7'd50, 4'd2, 1'b1, 2'd0, 7'd85, 2'd3}, // R2
    '{3'b010, 7'd100, 7'd80,  7'd50, 4'd2, 1'b1, 2'd1, 7'd50, 2'd1}, // R2
    '{3'b100, 7'd100, 7'd80,  7'd50, 4'd2, 1'b1, 2'd2, 7'd75, 2'd2}, // R2
    '{3'b111, 7'd100, 7'd80,  7'd50, 4'd3, 1'b1, 2'd0, 7'd85, 2'd3}, // R3
    '{3'b110, 7'd100, 7'd80,  7'd50, 4'd3, 1'b1, 2'd1, 7'd50, 2'd1}, // R3
    '{3'b110, 7'd100, 7'd80,  7'd90, 4'd3, 1'b1, 2'd2, 7'd75, 2'd2}, // R3
    '{3'b111, 7'd60,  7'd60,  7'd60, 4'd4, 1'b1, 2'd0, 7'd85, 2'd3}, // R4
    '{3'b110, 7'd60,  7'd70,  7'd70, 4'd4, 1'b1, 2'd1, 7'd50, 2'd1}, // R4
    '{3'b011, 7'd0,   7'd1,   7'd50, 4'd6, 1'b1, 2'd0, 7'd85, 2'd3}, // R6
    '{3'b011, 7'd99,  7'd127, 7'd50, 4'd6, 1'b1, 2'd1, 7'd50, 2'd1}, // R6
    '{3'b011, 7'd100, 7'd127, 7'd50, 4'd6, 1'b1, 2'd0, 7'd85, 2'd3}, // R6
    '{3'b101, 7'd0,   7'd80,  7'd2,  4'd6, 1'b1, 2'd2, 7'd75, 2'd2}, // R6
    '{3'b000, 7'd100, 7'd80,  7'd50, 4'd5, 1'b0, 2'd0, 7'd0,  2'd0}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  act = '0;
  logic [20:0] prio = '0;
  logic [20:0] pct = '0;
  logic [5:0]  lvl = '0;
  logic        valid;
  logic [1:0]  widx;
  logic [6:0]  opct;
  logic [1:0]  olvl;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  throttle_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .act_i(act), .prio_i(prio),
    .cpu_pct_i(pct), .gpu_lvl_i(lvl), .valid_o(valid),
    .win_idx_o(widx), .cpu_pct_o(opct), .gpu_lvl_o(olvl)
  );

  task automatic chk(input string req, input logic ev, input logic [1:0] ei,
                     input logic [6:0] ep, input logic [1:0] el);
    checks++;
    if (valid !== ev || widx !== ei || opct !== ep || olvl !== el) begin
      errors++;
      $display("FAIL %s: got v=%0d idx=%0d pct=%0d lvl=%0d exp v=%0d idx=%0d pct=%0d lvl=%0d",
               req, valid, widx, opct, olvl, ev, ei, ep, el);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    pct = {7'd75, 7'd50, 7'd85};
    lvl = {2'd2, 2'd1, 2'd3};
    prio = {7'd50, 7'd80, 7'd100};
    act = 3'b111;
    #(CLK_PERIOD * 2 + 1);
    chk("R1", 1'b0, 2'd0, 7'd0, 2'd0); // held in reset with sources active
    act = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0, 2'd0, 7'd0, 2'd0);

    for (int k = 0; k < NV; k++) begin
      act  = VEC[k].act;
      prio = {VEC[k].p2, VEC[k].p1, VEC[k].p0};
      @(negedge clk);
      chk($sformatf("R%0d", VEC[k].req), VEC[k].ev, VEC[k].eidx, VEC[k].epct, VEC[k].elvl);
    end

    // R7: no change before the edge, new value one edge later
    prio = {7'd50, 7'd80, 7'd100};
    act = 3'b010;
    @(negedge clk);
    chk("R7", 1'b1, 2'd1, 7'd50, 2'd1);
    act = 3'b001;
    #1;
    chk("R7", 1'b1, 2'd1, 7'd50, 2'd1);
    @(negedge clk);
    chk("R7", 1'b1, 2'd0, 7'd85, 2'd3);

    // R8: inactive sources' priority and payload do not matter
    prio = {7'd127, 7'd127, 7'd1};
    pct  = {7'd99, 7'd99, 7'd85};
    lvl  = {2'd0, 2'd0, 2'd3};
    @(negedge clk);
    chk("R8", 1'b1, 2'd0, 7'd85, 2'd3);
    prio = {7'd0, 7'd0, 7'd1};
    pct  = {7'd3, 7'd4, 7'd85};
    @(negedge clk);
    chk("R8", 1'b1, 2'd0, 7'd85, 2'd3);

    // R5: all idle with garbage on payloads
    act = '0;
    @(negedge clk);
    chk("R5", 1'b0, 2'd0, 7'd0, 2'd0);

    // R1: asynchronous reset mid-run
    act = 3'b100;
    @(negedge clk);
    chk("R2", 1'b1, 2'd2, 7'd3, 2'd0);
    rst_n = 1'b0;
    #1;
    chk("R1", 1'b0, 2'd0, 7'd0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    act = '0;
    @(negedge clk);
    chk("R1", 1'b0, 2'd0, 7'd0, 2'd0);

    finish_run();
  end
endmodule